// File: doc/BRIEF.md
# Extended State Save/Restore Sequencer

This block runs the control side of saving or restoring up to six processor state components to or from a memory area. It talks to memory through a single 64-bit word request port and hands the payload of each component to a separate mover through a start/done handshake. With each start it passes a mode and the byte address where that component's slot begins. A 64-bit header word at area offset 512 records which components hold saved data.

A save selects the components that are both enabled and requested. It first reads the existing header word. It then starts a store for each selected component, lowest index first, sets that component's bit in the header copy, and writes the header back as its last memory operation.

A restore reads the three header words at offsets 512, 520 and 528 and checks the first one. A bad header ends the sequence with a fault and no component is touched. A good header leads to a load or an initialise command for each selected component, chosen by that component's header bit.

Top module: `xss_seq`

## Requirements
- R1: A sequence acts on the components set in both `en_i` and `req_i` (bit i is component i), and only on those. It starts them one at a time in ascending index order. On a save every start carries mode 2'b00 (store).
- R2: A save first reads the header word at base+512, and does so before any component is started.
- R3: A save ends with exactly one memory write to base+512. It comes after every component has finished. The value is the header word that was read, with the bit of every stored component set and every other bit (upper 32 included) unchanged.
- R4: A restore reads the words at base+512, base+520 and base+528 in that order before any component is started, and issues no memory write.
- R5: A restore faults if the word read from offset 512 has any nonzero bit in bits 63:32, or any bit in 31:0 whose component is not enabled. A fault is a one-cycle pulse on `fault_o` with no `done_o`, no component start and no memory write.
- R6: On a valid restore each selected component is started with mode 2'b01 (load) if its bit in the 512 header word is set, and with mode 2'b10 (initialise) if it is clear.
- R7: The component slot offsets are 0, 160, 576, 1088, 1152 and 1664 for indices 0 to 5. `comp_addr_o` is base plus that offset.
- R8: Every memory and component address is the sum of base and offset ANDed with `amask_i`, as captured at start. Wrap within the mask is allowed.
- R9: A completed sequence gives a one-cycle pulse on `done_o`, after which `busy_o` is low. Out of reset all outputs are low.
- R10: Once `mem_req_o` is raised, it stays high with the same address and write flag until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sequence (sampled when idle) |
| restore_i | input | 1 | 1 = restore, 0 = save |
| base_i | input | AW | Byte base address of the area |
| amask_i | input | AW | Address-size mask |
| en_i | input | 6 | Enabled components |
| req_i | input | 6 | Requested components |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write flag |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 64 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 64 | Memory read data, valid with ack |
| comp_start_o | output | 6 | One-hot component start pulse |
| comp_mode_o | output | 2 | 00 store, 01 load, 10 initialise |
| comp_addr_o | output | AW | Component slot address |
| comp_done_i | input | 1 | Component transfer finished |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished pulse |
| fault_o | output | 1 | Header fault pulse |

## Verification
The per-cycle properties cover a number of rules. Component starts are one-hot, and a save never issues a load or initialise while a restore never issues a store. Memory requests hold steady until acknowledged and stay inside the address mask. Writes occur only on saves, a fault comes only from a restore, and `done_o` and `fault_o` never coincide. The ordering of header reads, component starts and the final header write can only be shown by the bench's scenarios. So can the header value written back, the fault decision across header patterns, and the exact slot addresses. The bench sweeps every enable mask against several request masks, headers and masked bases.

// File: rtl/xss_pkg.sv
package xss_pkg;
  localparam int NCOMP   = 6;
  localparam int HW      = 64;
  localparam int HDR_OFF = 512;

  typedef enum logic [1:0] {
    XM_STORE = 2'b00,
    XM_LOAD  = 2'b01,
    XM_INIT  = 2'b10
  } xmode_e;

  // byte offset of each component slot inside the area
  function automatic int unsigned comp_offset(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 160;
      2:       return 576;
      3:       return 1088;
      4:       return 1152;
      5:       return 1664;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/xss_pick.sv
module xss_pick #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]  set_i,
  input  logic [CW-1:0] from_i,
  output logic          found_o,
  output logic [CW-1:0] idx_o
);
  // lowest set bit at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (set_i[i] && (CW'(i) >= from_i)) begin
        found_o = 1'b1;
        idx_o   = CW'(i);
      end
    end
  end
endmodule

// File: rtl/xss_hdr_chk.sv
module xss_hdr_chk
  import xss_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [HW-1:0] hdr_i,
  input  logic [N-1:0]  en_i,
  output logic          bad_o
);
  logic [31:0] allowed;
  assign allowed = {{(32-N){1'b0}}, en_i};
  assign bad_o   = (|hdr_i[63:32]) | (|(hdr_i[31:0] & ~allowed));
endmodule

// File: rtl/xss_addr.sv
module xss_addr
  import xss_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] mask_i,
  input  logic          is_hdr_i,
  input  logic [1:0]    hword_i,
  input  logic [CW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] off;
  always_comb begin
    if (is_hdr_i) off = AW'(HDR_OFF + 8 * int'(hword_i));
    else          off = AW'(comp_offset(32'(idx_i)));
  end
  assign addr_o = (base_i + off) & mask_i;
endmodule

// File: rtl/xss_seq.sv
module xss_seq
  import xss_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             restore_i,
  input  logic [AW-1:0]    base_i,
  input  logic [AW-1:0]    amask_i,
  input  logic [NCOMP-1:0] en_i,
  input  logic [NCOMP-1:0] req_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [HW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [HW-1:0]    mem_rdata_i,
  output logic [NCOMP-1:0] comp_start_o,
  output logic [1:0]       comp_mode_o,
  output logic [AW-1:0]    comp_addr_o,
  input  logic             comp_done_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o
);
  localparam int CW = $clog2(NCOMP + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HRD0, ST_HRD1, ST_HRD2, ST_CHECK, ST_PICK, ST_WAIT, ST_HWR
  } st_e;

  st_e              st_q;
  logic             restore_q;
  logic [AW-1:0]    base_q, amask_q;
  logic [NCOMP-1:0] set_q, en_q;
  logic [HW-1:0]    hdr_q;
  logic [CW-1:0]    cur_q;

  logic [AW-1:0]    base_use, mask_use, hdr_addr, cmp_addr;
  logic [1:0]       hword;
  logic             pick_found, hdr_bad;
  logic [CW-1:0]    pick_idx;

  assign base_use = (st_q == ST_IDLE) ? base_i  : base_q;
  assign mask_use = (st_q == ST_IDLE) ? amask_i : amask_q;
  assign busy_o   = (st_q != ST_IDLE);

  // header word to address next: 512 on entry and write-back, then 520, 528
  always_comb begin
    case (st_q)
      ST_HRD0: hword = 2'd1;
      ST_HRD1: hword = 2'd2;
      default: hword = 2'd0;
    endcase
  end

  xss_addr #(.AW(AW), .CW(CW)) u_hadr (
    .base_i(base_use), .mask_i(mask_use), .is_hdr_i(1'b1),
    .hword_i(hword), .idx_i({CW{1'b0}}), .addr_o(hdr_addr)
  );

  xss_addr #(.AW(AW), .CW(CW)) u_cadr (
    .base_i(base_use), .mask_i(mask_use), .is_hdr_i(1'b0),
    .hword_i(2'b00), .idx_i(pick_idx), .addr_o(cmp_addr)
  );

  xss_pick #(.N(NCOMP), .CW(CW)) u_pick (
    .set_i(set_q), .from_i(cur_q), .found_o(pick_found), .idx_o(pick_idx)
  );

  xss_hdr_chk #(.N(NCOMP)) u_chk (
    .hdr_i(hdr_q), .en_i(en_q), .bad_o(hdr_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      restore_q    <= 1'b0;
      base_q       <= '0;
      amask_q      <= '0;
      set_q        <= '0;
      en_q         <= '0;
      hdr_q        <= '0;
      cur_q        <= '0;
      mem_req_o    <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_addr_o   <= '0;
      mem_wdata_o  <= '0;
      comp_start_o <= '0;
      comp_mode_o  <= XM_STORE;
      comp_addr_o  <= '0;
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
    end else begin
      done_o       <= 1'b0;
      fault_o      <= 1'b0;
      comp_start_o <= '0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          restore_q  <= restore_i;
          base_q     <= base_i;
          amask_q    <= amask_i;
          set_q      <= en_i & req_i;
          en_q       <= en_i;
          cur_q      <= '0;
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= hdr_addr;
          st_q       <= ST_HRD0;
        end
        ST_HRD0: if (mem_ack_i) begin
          hdr_q <= mem_rdata_i;
          if (restore_q) begin
            mem_addr_o <= hdr_addr;
            st_q       <= ST_HRD1;
          end else begin
            mem_req_o <= 1'b0;
            st_q      <= ST_PICK;
          end
        end
        ST_HRD1: if (mem_ack_i) begin
          mem_addr_o <= hdr_addr;
          st_q       <= ST_HRD2;
        end
        ST_HRD2: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          st_q      <= ST_CHECK;
        end
        ST_CHECK: begin
          if (hdr_bad) begin
            fault_o <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (pick_found) begin
            cur_q        <= pick_idx;
            comp_start_o <= NCOMP'(1) << pick_idx;
            comp_addr_o  <= cmp_addr;
            if (!restore_q)          comp_mode_o <= XM_STORE;
            else if (hdr_q[pick_idx]) comp_mode_o <= XM_LOAD;
            else                     comp_mode_o <= XM_INIT;
            st_q <= ST_WAIT;
          end else if (!restore_q) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= hdr_addr;
            mem_wdata_o <= hdr_q;
            st_q        <= ST_HWR;
          end else begin
            done_o <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_WAIT: if (comp_done_i) begin
          if (!restore_q) hdr_q[cur_q] <= 1'b1;
          cur_q <= cur_q + CW'(1);
          st_q  <= ST_PICK;
        end
        ST_HWR: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          mem_we_o  <= 1'b0;
          done_o    <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xss_seq_chk.sv
module xss_seq_chk
  import xss_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_ack_i,
  input logic [NCOMP-1:0] comp_start_o,
  input logic [1:0]       comp_mode_o,
  input logic             done_o,
  input logic             fault_o,
  input logic             restore_q,
  input logic [AW-1:0]    amask_q
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R8
  addr_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> ((mem_addr_o & ~amask_q) == '0));

  // R1
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(comp_start_o));

  // R1
  save_store_mode_chk: assert property (@(posedge clk) disable iff (rst)
    ((|comp_start_o) && !restore_q) |-> (comp_mode_o == 2'b00));

  // R6
  restore_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    ((|comp_start_o) && restore_q) |-> (comp_mode_o != 2'b00));

  // R4
  write_only_on_save_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> !restore_q);

  // R5
  fault_from_restore_chk: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> restore_q);

  // R5
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fault_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind xss_seq xss_seq_chk #(.AW(AW)) u_seq_chk (
  .clk(clk), .rst(rst), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i), .comp_start_o(comp_start_o),
  .comp_mode_o(comp_mode_o), .done_o(done_o), .fault_o(fault_o),
  .restore_q(restore_q), .amask_q(amask_q)
);

// File: tb/test_xss_seq.sv
module test_xss_seq;
  import xss_pkg::*;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             start_i = 1'b0, restore_i = 1'b0;
  logic [AW-1:0]    base_i = '0, amask_i = '1;
  logic [NCOMP-1:0] en_i = '0, req_i = '0;
  logic             mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [AW-1:0]    mem_addr_o, comp_addr_o;
  logic [63:0]      mem_wdata_o, mem_rdata_i = '0;
  logic [NCOMP-1:0] comp_start_o;
  logic [1:0]       comp_mode_o;
  logic             comp_done_i = 1'b0, busy_o, done_o, fault_o;

  xss_seq #(.AW(AW)) i_xss_seq (.*);

  int checks = 0, fails = 0, ev = 0;
  logic [63:0] hmem [3];
  logic [AW-1:0] rd_a [8];
  int rd_ev [8];
  int rd_n = 0, wr_n = 0, wr_ev = 0, c_n = 0;
  logic [AW-1:0] wr_a;
  logic [63:0] wr_d;
  int c_idx [8], c_ev [8];
  logic [1:0] c_mode [8];
  logic [AW-1:0] c_addr [8];
  logic [AW-1:0] cur_base, cur_mask;
  logic mpend = 1'b0, cpend = 1'b0;
  logic [AW-1:0] paddr;

  function automatic int slot(input int i);
    int t [6] = '{0, 160, 576, 1088, 1152, 1664};
    return t[i];
  endfunction

  function automatic logic [AW-1:0] ea(input int off);
    return (cur_base + AW'(off)) & cur_mask;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory responder: acks on the second negedge a request is seen
  always @(negedge clk) begin
    if (mem_ack_i) mem_ack_i = 1'b0;
    else if (mem_req_o) begin
      if (!mpend) begin
        mpend = 1'b1;
        paddr = mem_addr_o;
      end else begin
        chk(mem_addr_o == paddr, "R10", "request address held", 64'(mem_addr_o), 64'(paddr));
        mpend = 1'b0;
        mem_ack_i = 1'b1;
        ev++;
        if (mem_we_o) begin
          wr_n++; wr_a = mem_addr_o; wr_d = mem_wdata_o; wr_ev = ev;
        end else begin
          if (rd_n < 8) begin rd_a[rd_n] = mem_addr_o; rd_ev[rd_n] = ev; end
          rd_n++;
          if (mem_addr_o == ea(512))      mem_rdata_i = hmem[0];
          else if (mem_addr_o == ea(520)) mem_rdata_i = hmem[1];
          else if (mem_addr_o == ea(528)) mem_rdata_i = hmem[2];
          else                            mem_rdata_i = 64'hDEAD_0000_0000_BEEF;
        end
      end
    end
  end

  // component responder: done one cycle after the start is seen
  always @(negedge clk) begin
    if (comp_done_i) comp_done_i = 1'b0;
    else if (cpend) begin comp_done_i = 1'b1; cpend = 1'b0; end
    else if (|comp_start_o) begin
      ev++;
      if (c_n < 8) begin
        c_idx[c_n] = -1;
        for (int i = 0; i < NCOMP; i++) if (comp_start_o[i]) c_idx[c_n] = i;
        c_mode[c_n] = comp_mode_o; c_addr[c_n] = comp_addr_o; c_ev[c_n] = ev;
      end
      c_n++;
      cpend = 1'b1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  task automatic run(input bit rs, input logic [AW-1:0] b, input logic [AW-1:0] m,
                     input logic [5:0] e, input logic [5:0] q);
    int cyc = 0;
    bit got_done = 0, got_fault = 0, seq_ok = 1, exp_fault;
    int k = 0, first_c = 1 << 30, last_c = 0;
    logic [5:0] set;
    logic [63:0] exp_hdr;
    rd_n = 0; wr_n = 0; c_n = 0;
    cur_base = b; cur_mask = m;
    set = e & q;
    @(negedge clk);
    restore_i = rs; base_i = b; amask_i = m; en_i = e; req_i = q; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && !fault_o && cyc < 500) begin @(negedge clk); cyc++; end
    got_done = done_o; got_fault = fault_o;
    exp_fault = rs && ((hmem[0][63:32] != 0) || ((hmem[0][31:0] & ~32'(e)) != 0));
    // R5 R9 outcome
    chk(got_done == !exp_fault && got_fault == exp_fault, exp_fault ? "R5" : "R9",
        "outcome done/fault", {62'd0, got_done, got_fault}, {62'd0, !exp_fault, exp_fault});
    // R1 R6 R7 R8 component sequence
    if (!exp_fault) begin
      for (int i = 0; i < NCOMP; i++) if (set[i]) begin
        logic [1:0] em;
        em = !rs ? 2'b00 : (hmem[0][i] ? 2'b01 : 2'b10);
        if (k >= c_n || c_idx[k] != i || c_mode[k] != em || c_addr[k] != ea(slot(i)))
          seq_ok = 0;
        k++;
      end
    end
    if (c_n != k) seq_ok = 0;
    chk(seq_ok, rs ? "R6" : "R1", "component order/mode/addr (R7 R8)", 64'(c_n), 64'(k));
    for (int i = 0; i < c_n && i < 8; i++) begin
      if (c_ev[i] < first_c) first_c = c_ev[i];
      if (c_ev[i] > last_c)  last_c = c_ev[i];
    end
    if (!rs) begin
      // R2
      chk(rd_n == 1 && rd_a[0] == ea(512) && rd_ev[0] < first_c, "R2", "header read first",
          64'(rd_a[0]), 64'(ea(512)));
      // R3
      exp_hdr = hmem[0] | 64'(set);
      chk(wr_n == 1 && wr_a == ea(512) && wr_d == exp_hdr && wr_ev > last_c, "R3",
          "header write-back", wr_d, exp_hdr);
    end else begin
      // R4
      chk(rd_n == 3 && rd_a[0] == ea(512) && rd_a[1] == ea(520) && rd_a[2] == ea(528)
          && rd_ev[2] < first_c, "R4", "three header reads", 64'(rd_n), 64'd3);
      chk(wr_n == 0, exp_fault ? "R5" : "R4", "no write on restore", 64'(wr_n), 64'd0);
    end
    @(negedge clk);
    // R9
    chk(!done_o && !fault_o && !busy_o, "R9", "single pulse then idle",
        {61'd0, done_o, fault_o, busy_o}, 64'd0);
  endtask

  initial begin
    logic [AW-1:0] bl [4] = '{16'h0000, 16'h3F00, 16'h0F80, 16'h7FF8};
    logic [AW-1:0] ml [4] = '{16'hFFFF, 16'hFFFF, 16'h0FFF, 16'h7FFF};
    hmem[0] = '0; hmem[1] = '0; hmem[2] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!mem_req_o && !mem_we_o && comp_start_o == 0 && !busy_o && !done_o && !fault_o,
        "R9", "reset state", {58'd0, mem_req_o, mem_we_o, |comp_start_o, busy_o, done_o, fault_o}, 64'd0);
    for (int op = 0; op < 2; op++) begin
      for (int e = 0; e < 64; e++) begin
        for (int r = 0; r < 8; r++) begin
          logic [5:0] q, lo;
          int bi;
          q  = (r == 0) ? 6'h3F : 6'((r * 13 + e * 5) & 63);
          bi = (e + r) % 4;
          if (op == 0) begin
            hmem[0] = {32'hA5C3_0000 | 32'(r), 32'h0000_1200 | 32'(6'(e) ^ 6'h2A)};
          end else begin
            lo = 6'(e) ^ 6'(r * 9);
            if (r != 3) lo = lo & 6'(e);
            hmem[0] = {32'd0, 26'd0, lo};
            if (r == 5) hmem[0][40] = 1'b1;
            if (r == 6) hmem[0][10] = 1'b1;
          end
          hmem[1] = 64'h1111_2222_3333_0000 | 64'(r);
          hmem[2] = 64'h4444_5555_6666_0000 | 64'(e);
          run(op[0], bl[bi], ml[bi], 6'(e), q);
        end
      end
    end
    summary();
    $finish;
  end
endmodule